// File: doc/BRIEF.md
# BCD Calendar Clock with Freeze

This block keeps the time of day and the calendar as packed BCD, from seconds up to a two-digit year, plus a day-of-week counter. A prescaler turns a 32.768 kHz enable pulse (`ref_en`) into one advance of the time per second. The live time sits in internal counters. The host never reads those counters directly. It reads a bank of user registers that copies the counters once per second, and it reaches that bank over a 4-bit address, 8-bit data register port with a combinational read path.

A freeze control bit stops the copy so that the host can read several fields that all belong to the same second. The counters keep running while the copy is frozen. The freeze bit is also the only way to set the clock. Time fields accept writes only while frozen, and a write to any of them marks the bank as dirty. Clearing the freeze bit with the bank dirty loads the bank into the counters and restarts the prescaler. The hours field can be shown in 24-hour or 12-hour form. A run bit decides whether the clock keeps counting while the chip is on backup supply.

Top module: `bcd_cal_clock`

## Requirements
- R1: Seconds and minutes count 00 to 59 in BCD, and a field that reaches 59 wraps to 00 and carries into the next field. Register addresses are: 0 seconds, 1 minutes, 2 hours, 3 date, 4 day-of-week, 5 month, 6 year, 0xE control.
- R2: The date wraps from the last day of the month to 01 and advances the month. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00. Day-of-week runs 01 to 07 and wraps to 01 at the same midnight step as the date.
- R3: February has 29 days when the year's value is divisible by 4 (year 00 included) and 28 days otherwise. April, June, September and November have 30 days, and every other month has 31.
- R4: While control bit 3 (freeze) is 1, the user registers hold their values but the counters keep counting. Clearing freeze without having written a time field makes the bank show the time as it ran on through the frozen period.
- R5: All user time registers are refreshed from the counters at the same moment, once per second. A freeze write that lands on the refresh cycle lets that refresh complete.
- R6: Control bit 1 set to 1 selects 24-hour hours (00 to 23). Set to 0, it selects 12-hour hours, where bit 7 is the PM flag and the BCD value runs 01 to 12. In 12-hour form the steps are 11 AM to 12 PM, 12 PM to 01 PM, and 11 PM to 12 AM, with the date advancing on the last of these.
- R7: Time fields written while frozen are loaded into the counters when freeze is cleared. The next second then elapses after SEC_DIV further `ref_en` pulses. Writes to time fields while not frozen are ignored.
- R8: Control bit 2 (run) set to 0 halts the counters only while `backup` is 1. With `backup` at 0 the clock always runs.
- R9: Unused bits cannot be written and read as 0. The write masks are: seconds and minutes 0x7F, hours 0xBF, date 0x3F, day-of-week 0x07, month 0x1F, control 0x0E. Addresses 7 to 0xD and 0xF read 0.
- R10: After reset the bank reads 00:00:00 in 24-hour form, with date 01, day-of-week 01, month 01, year 00 and control 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| backup | input | 1 | High while the chip runs from the backup supply |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
The bench builds the block with SEC_DIV = 4 and holds `ref_en` high, so one second lasts four clock cycles. At that rate every year, month, leap-February and 12-hour rollover can be reached in a few cycles, each from a time loaded through the freeze path. Knowing each second to the cycle also lets the bench place a freeze write exactly on the refresh cycle and one cycle before it. It can then count the seconds that pass behind a frozen bank.

// File: rtl/bcd_cal_pkg.sv
`timescale 1ns/1ps
package bcd_cal_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] dow;
    logic [7:0] date;
    logic [4:0] hr;    // binary 0..23
    logic [7:0] mn;
    logic [7:0] sc;
  } cal_t;

  function automatic logic [6:0] bcd2bin(input logic [7:0] b);
    return {3'b000, b[7:4]} * 7'd10 + {3'b000, b[3:0]};
  endfunction

  function automatic logic [7:0] bin2bcd(input logic [6:0] v);
    logic [6:0] t;
    logic [6:0] o;
    t = v / 7'd10;
    o = v % 7'd10;
    return {t[3:0], o[3:0]};
  endfunction

  // BCD increment that wraps from hi back to lo
  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] hi,
                                          input logic [7:0] lo);
    if (v == hi)             return lo;
    else if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                     return v + 8'd1;
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] mon, input logic [7:0] yr);
    logic [6:0] y;
    y = bcd2bin(yr);
    case (mon)
      8'h02:                      return (y[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] hr_to_reg(input logic [4:0] h, input logic fmt24);
    logic [4:0] h12;
    logic [7:0] b;
    h12 = (h >= 5'd12) ? h - 5'd12 : h;
    if (h12 == 5'd0) h12 = 5'd12;
    if (fmt24) return bin2bcd({2'b00, h});
    b = bin2bcd({2'b00, h12});
    return {h >= 5'd12, 1'b0, b[5:0]};
  endfunction

  function automatic logic [4:0] hr_from_reg(input logic [7:0] r, input logic fmt24);
    logic [6:0] v;
    v = bcd2bin({2'b00, r[5:0]});
    if (fmt24)            return v[4:0];
    else if (v == 7'd12)  return r[7] ? 5'd12 : 5'd0;
    else                  return r[7] ? v[4:0] + 5'd12 : v[4:0];
  endfunction

endpackage

// File: rtl/cal_tick_gen.sv
`timescale 1ns/1ps
module cal_tick_gen #(
  parameter int SEC_DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  input  logic run,
  input  logic clr,
  output logic sec_tick
);
  localparam int CW = (SEC_DIV > 2) ? $clog2(SEC_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SEC_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          tick_q, tick_n;

  always_comb begin
    cnt_n  = cnt_q;
    tick_n = 1'b0;
    if (clr) begin
      cnt_n = '0;
    end else if (ref_en && run) begin
      if (cnt_q == LAST) begin
        cnt_n  = '0;
        tick_n = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      tick_q <= tick_n;
    end
  end

  assign sec_tick = tick_q;
endmodule

// File: rtl/cal_time_chain.sv
`timescale 1ns/1ps
module cal_time_chain
  import bcd_cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic ld,
  input  cal_t ld_val,
  output cal_t cur
);
  cal_t cur_q, cur_n;
  logic [7:0] last_day;

  always_comb begin
    cur_n    = cur_q;
    last_day = month_end(cur_q.mon, cur_q.yr);
    if (ld) begin
      cur_n = ld_val;
    end else if (adv) begin
      cur_n.sc = bcd_step(cur_q.sc, 8'h59, 8'h00);
      if (cur_q.sc == 8'h59) begin
        cur_n.mn = bcd_step(cur_q.mn, 8'h59, 8'h00);
        if (cur_q.mn == 8'h59) begin
          cur_n.hr = (cur_q.hr == 5'd23) ? 5'd0 : cur_q.hr + 5'd1;
          if (cur_q.hr == 5'd23) begin
            cur_n.dow  = bcd_step(cur_q.dow, 8'h07, 8'h01);
            cur_n.date = bcd_step(cur_q.date, last_day, 8'h01);
            if (cur_q.date == last_day) begin
              cur_n.mon = bcd_step(cur_q.mon, 8'h12, 8'h01);
              if (cur_q.mon == 8'h12) cur_n.yr = bcd_step(cur_q.yr, 8'h99, 8'h00);
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '{yr: 8'h00, mon: 8'h01, dow: 8'h01, date: 8'h01,
                 hr: 5'd0, mn: 8'h00, sc: 8'h00};
    end else begin
      cur_q <= cur_n;
    end
  end

  assign cur = cur_q;

  // R1
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && cur_q.sc == 8'h59) |=> (cur_q.sc == 8'h00));
  // R2
  midnight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && cur_q.sc == 8'h59 && cur_q.mn == 8'h59 && cur_q.hr == 5'd23)
      |=> (cur_q.hr == 5'd0 && cur_q.date != $past(cur_q.date)));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !ld) |=> $stable(cur_q));
endmodule

// File: rtl/cal_user_bank.sv
`timescale 1ns/1ps
module cal_user_bank
  import bcd_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  output logic [7:0] rdata,
  input  cal_t       live,
  input  logic       refresh,
  output logic       ld,
  output cal_t       ld_val,
  output logic       run,
  output logic       frozen
);
  localparam logic [3:0] A_SEC = 4'h0, A_MIN = 4'h1, A_HR = 4'h2, A_DATE = 4'h3,
                         A_DOW = 4'h4, A_MON = 4'h5, A_YR = 4'h6, A_CTL = 4'hE;

  logic [7:0] sc_q, mn_q, hr_q, dt_q, dw_q, mo_q, yr_q;
  logic [7:0] sc_n, mn_n, hr_n, dt_n, dw_n, mo_n, yr_n;
  logic       frz_q, run_q, h24_q, dirty_q;
  logic       frz_n, run_n, h24_n, dirty_n;
  logic       wr_time, wr_ctl, release_w;

  assign wr_time   = wr_en && frz_q && (addr <= A_YR);
  assign wr_ctl    = wr_en && (addr == A_CTL);
  assign release_w = wr_ctl && frz_q && !wdata[3];
  assign ld        = release_w && dirty_q;

  always_comb begin
    {sc_n, mn_n, hr_n, dt_n, dw_n, mo_n, yr_n} = {sc_q, mn_q, hr_q, dt_q, dw_q, mo_q, yr_q};
    {frz_n, run_n, h24_n} = {frz_q, run_q, h24_q};
    dirty_n = dirty_q;
    if (refresh && !frz_q) begin
      sc_n = live.sc;   mn_n = live.mn;   hr_n = hr_to_reg(live.hr, h24_q);
      dt_n = live.date; dw_n = live.dow;  mo_n = live.mon; yr_n = live.yr;
    end
    if (wr_time) begin
      dirty_n = 1'b1;
      case (addr)
        A_SEC:   sc_n = wdata & 8'h7F;
        A_MIN:   mn_n = wdata & 8'h7F;
        A_HR:    hr_n = wdata & 8'hBF;
        A_DATE:  dt_n = wdata & 8'h3F;
        A_DOW:   dw_n = wdata & 8'h07;
        A_MON:   mo_n = wdata & 8'h1F;
        default: yr_n = wdata;
      endcase
    end
    if (wr_ctl) begin
      frz_n = wdata[3];
      run_n = wdata[2];
      h24_n = wdata[1];
    end
    if (release_w) dirty_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sc_q, mn_q, hr_q} <= '0;
      dt_q    <= 8'h01;
      dw_q    <= 8'h01;
      mo_q    <= 8'h01;
      yr_q    <= 8'h00;
      frz_q   <= 1'b0;
      run_q   <= 1'b1;
      h24_q   <= 1'b1;
      dirty_q <= 1'b0;
    end else begin
      {sc_q, mn_q, hr_q, dt_q, dw_q, mo_q, yr_q} <= {sc_n, mn_n, hr_n, dt_n, dw_n, mo_n, yr_n};
      {frz_q, run_q, h24_q} <= {frz_n, run_n, h24_n};
      dirty_q <= dirty_n;
    end
  end

  assign ld_val = '{yr: yr_q, mon: mo_q, dow: dw_q, date: dt_q,
                    hr: hr_from_reg(hr_q, wdata[1]), mn: mn_q, sc: sc_q};
  assign run    = run_q;
  assign frozen = frz_q;

  always_comb begin
    case (addr)
      A_SEC:   rdata = sc_q;
      A_MIN:   rdata = mn_q;
      A_HR:    rdata = hr_q;
      A_DATE:  rdata = dt_q;
      A_DOW:   rdata = dw_q;
      A_MON:   rdata = mo_q;
      A_YR:    rdata = yr_q;
      A_CTL:   rdata = {4'b0000, frz_q, run_q, h24_q, 1'b0};
      default: rdata = 8'h00;
    endcase
  end

  // R4
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && !wr_time) |=> $stable({sc_q, mn_q, hr_q, dt_q, dw_q, mo_q, yr_q}));
  // R9
  ctl_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CTL) |-> (rdata[7:4] == 4'b0000 && !rdata[0]));
  // R7
  load_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> (frz_q && dirty_q));
endmodule

// File: rtl/bcd_cal_clock.sv
`timescale 1ns/1ps
module bcd_cal_clock
  import bcd_cal_pkg::*;
#(
  parameter int SEC_DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_en,
  input  logic       backup,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr_en,
  output logic [7:0] rdata
);
  cal_t live, ld_val;
  logic ld, run_bit, frozen, sec_tick, running, adv, refresh_q;

  assign running = !(backup && !run_bit);
  assign adv     = sec_tick && running;

  cal_tick_gen #(.SEC_DIV(SEC_DIV)) tick_i (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .run(running), .clr(ld), .sec_tick(sec_tick)
  );

  cal_time_chain chain_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .ld(ld), .ld_val(ld_val), .cur(live)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) refresh_q <= 1'b0;
    else        refresh_q <= adv && !ld;
  end

  cal_user_bank bank_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rdata(rdata),
    .live(live), .refresh(refresh_q), .ld(ld), .ld_val(ld_val), .run(run_bit),
    .frozen(frozen)
  );

  // R8
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (backup && !run_bit && !ld && !frozen) |=> !refresh_q);
endmodule

// File: tb/bcd_cal_clock_tb.sv
`timescale 1ns/1ps
module bcd_cal_clock_tb_top;
  localparam int DIV = 4;

  typedef struct packed {
    logic [7:0] s, m, h, d, w, mo, y;
    logic       f24;
    logic [7:0] n;
    logic [7:0] es, em, eh, ed, ew, emo, ey;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'h59,8'h59,8'h23,8'h31,8'h07,8'h12,8'h99,1'b1,8'd1, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00},
    '{8'h59,8'h59,8'h23,8'h28,8'h03,8'h02,8'h23,1'b1,8'd1, 8'h00,8'h00,8'h00,8'h01,8'h04,8'h03,8'h23},
    '{8'h59,8'h59,8'h23,8'h28,8'h03,8'h02,8'h24,1'b1,8'd1, 8'h00,8'h00,8'h00,8'h29,8'h04,8'h02,8'h24},
    '{8'h59,8'h59,8'h23,8'h29,8'h02,8'h02,8'h00,1'b1,8'd1, 8'h00,8'h00,8'h00,8'h01,8'h03,8'h03,8'h00},
    '{8'h59,8'h59,8'h23,8'h30,8'h05,8'h04,8'h25,1'b1,8'd1, 8'h00,8'h00,8'h00,8'h01,8'h06,8'h05,8'h25},
    '{8'h59,8'h59,8'h11,8'h10,8'h01,8'h06,8'h25,1'b0,8'd1, 8'h00,8'h00,8'h92,8'h10,8'h01,8'h06,8'h25},
    '{8'h59,8'h59,8'h92,8'h10,8'h01,8'h06,8'h25,1'b0,8'd1, 8'h00,8'h00,8'h81,8'h10,8'h01,8'h06,8'h25},
    '{8'h59,8'h59,8'h91,8'h05,8'h07,8'h06,8'h25,1'b0,8'd1, 8'h00,8'h00,8'h12,8'h06,8'h01,8'h06,8'h25},
    '{8'h58,8'h59,8'h09,8'h15,8'h04,8'h08,8'h25,1'b1,8'd3, 8'h01,8'h00,8'h10,8'h15,8'h04,8'h08,8'h25}
  };

  logic       clk, rst_n, ref_en, backup, wr_en;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  int         n_chk, n_bad;
  logic       done;

  bcd_cal_clock #(.SEC_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .backup(backup),
    .addr(addr), .wdata(wdata), .wr_en(wr_en), .rdata(rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    addr = a;
    #0.5;
    v = rdata;
  endtask

  task automatic rdchk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    done = 1'b0;
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] a, b;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; ref_en = 1'b1; backup = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    // R10 reset state (checked before the first second elapses)
    rdchk("R10 sec", 4'h0, 8'h00); rdchk("R10 min", 4'h1, 8'h00);
    rdchk("R10 hr", 4'h2, 8'h00);  rdchk("R10 date", 4'h3, 8'h01);
    rdchk("R10 dow", 4'h4, 8'h01); rdchk("R10 mon", 4'h5, 8'h01);
    rdchk("R10 yr", 4'h6, 8'h00);  rdchk("R10 ctl", 4'hE, 8'h06);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R3 R6 R7 rollovers loaded through the freeze path
    for (int i = 0; i < NV; i++) begin
      wr(4'hE, {4'b0000, 1'b1, 1'b1, VEC[i].f24, 1'b0});
      wr(4'h0, VEC[i].s); wr(4'h1, VEC[i].m); wr(4'h2, VEC[i].h);
      wr(4'h3, VEC[i].d); wr(4'h4, VEC[i].w); wr(4'h5, VEC[i].mo);
      wr(4'h6, VEC[i].y);
      wr(4'hE, {4'b0000, 1'b0, 1'b1, VEC[i].f24, 1'b0});
      repeat (4 * VEC[i].n + 3) @(negedge clk);
      rdchk("R1 sec", 4'h0, VEC[i].es);  rdchk("R1 min", 4'h1, VEC[i].em);
      rdchk("R6 hr", 4'h2, VEC[i].eh);   rdchk("R2 date", 4'h3, VEC[i].ed);
      rdchk("R2 dow", 4'h4, VEC[i].ew);  rdchk("R3 mon", 4'h5, VEC[i].emo);
      rdchk("R2 yr", 4'h6, VEC[i].ey);
    end

    // R7: a time write without freeze is ignored (last vector left sec at 01, next refresh 2 cycles away)
    wr(4'h0, 8'h33);
    rdchk("R7 ignored write", 4'h0, 8'h01);

    // R9: unused bits and unmapped addresses
    wr(4'hE, 8'hFF);
    rdchk("R9 ctl mask", 4'hE, 8'h0E);
    wr(4'h0, 8'hFF); rdchk("R9 sec mask", 4'h0, 8'h7F);
    wr(4'h3, 8'hFF); rdchk("R9 date mask", 4'h3, 8'h3F);
    wr(4'h2, 8'hFF); rdchk("R9 hr mask", 4'h2, 8'hBF);
    wr(4'h7, 8'hFF); rdchk("R9 unmapped", 4'h7, 8'h00);

    // R5: freeze landing on the refresh cycle lets it complete
    wr(4'h0, 8'h10); wr(4'h1, 8'h00); wr(4'h2, 8'h00); wr(4'h3, 8'h01);
    wr(4'hE, 8'h06);                 // load at E0
    repeat (5) @(negedge clk);
    wr(4'hE, 8'h0E);                 // lands on E6, the refresh edge
    rdchk("R5 refresh completes", 4'h0, 8'h11);
    rdchk("R5 min together", 4'h1, 8'h00);
    // R5: freeze one cycle before the refresh blocks it
    wr(4'h0, 8'h10);
    wr(4'hE, 8'h06);
    repeat (4) @(negedge clk);
    wr(4'hE, 8'h0E);                 // lands on E5
    rdchk("R5 refresh blocked", 4'h0, 8'h10);

    // R4: bank holds while frozen, counters keep running
    wr(4'h0, 8'h17);
    wr(4'hE, 8'h06);                 // load at E0
    repeat (11) @(negedge clk);
    wr(4'hE, 8'h0E);                 // freeze at E12
    rdchk("R4 frozen value", 4'h0, 8'h19);
    repeat (12) @(negedge clk);
    rdchk("R4 still frozen", 4'h0, 8'h19);
    wr(4'hE, 8'h06);                 // release without writes at E25
    repeat (6) @(negedge clk);
    rdchk("R4 counters ran on", 4'h0, 8'h24);

    // R8: run bit 0 halts only in backup mode
    wr(4'hE, 8'h02);
    backup = 1'b1;
    repeat (8) @(negedge clk);
    rd(4'h0, a);
    repeat (40) @(negedge clk);
    rdchk("R8 halted in backup", 4'h0, a);
    backup = 1'b0;
    repeat (40) @(negedge clk);
    rd(4'h0, b);
    n_chk++;
    if (b == a) begin
      n_bad++;
      $display("FAIL R8 runs on main power: got %02h expected change from %02h", b, a);
    end
    wr(4'hE, 8'h06);
    backup = 1'b1;
    rd(4'h0, a);
    repeat (40) @(negedge clk);
    rd(4'h0, b);
    n_chk++;
    if (b == a) begin
      n_bad++;
      $display("FAIL R8 runs in backup with run set: got %02h expected change from %02h", b, a);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule